// File: doc/BRIEF.md
# Mixed Miss Queue with Bus Issue

This block sits between the first-level instruction and data caches and the system bus interface. It takes miss requests from both caches and places each one in one of four miss slots. It sends the slots to the bus as read transactions, tagged, in the order the misses arrived. Read data comes back one full 256-bit line per beat, in any order. The block matches each beat to its slot by tag, hands the line to the caches together with its address and its origin, and frees the slot.

Next to the miss slots sits a single cast-out buffer that holds one dirty victim line waiting to be written back. Normally a waiting miss goes to the bus before the cast-out. The cast-out goes first when the oldest waiting miss maps to the same cache set as the victim, because that miss would refill the line the victim still occupies. A miss to a line that is already queued joins the existing slot and uses no new one. Up to five bus transactions can be in flight: four reads and one write.

Top module: `fillq_top`

## Requirements
- R1: The queue holds at most four miss slots. While all four are occupied, a request that does not match a queued line is refused: `req_ready` is low and `slots_used` does not change.
- R2: At most one slot is of instruction origin. A new instruction miss that matches no queued line is refused while an instruction-origin slot exists. It is accepted again from the cycle after that slot retires.
- R3: `bus_inflight` equals the number of issued read slots not yet returned plus one while an issued cast-out is unacknowledged. It reaches five with four reads and one write outstanding.
- R4: A return beat that matches an issued slot raises `fill_valid` in the same cycle. On that beat `fill_data` equals the full 256-bit `rsp_data`, `fill_addr` is the slot's line address, and `fill_inst` is high for an instruction-origin slot. The slot is free from the next cycle.
- R5: A newly allocated slot takes the lowest free index. A read is issued with `bus_req_tag` equal to its slot index (0 to 3), and a cast-out is issued with tag 4. Returns are matched by tag in any order. A return whose tag names no issued slot changes nothing.
- R6: Waiting misses are issued to the bus in the order they were accepted, one per cycle while `bus_req_ready` is high.
- R7: The set index is the low `SET_W` bits (6 by default) of a line address. A pending cast-out is issued before the oldest waiting miss when their set indexes are equal. When they differ, the miss goes first. With no waiting miss, the cast-out is issued. A write is marked with `bus_req_write` high and carries the victim line on `bus_req_data`.
- R8: A request whose line address equals that of any queued slot is accepted (`req_ready` high) even when the queue is full or already holds an instruction slot, and no new slot is taken.
- R9: `cwb_ready` is high only while the cast-out buffer is empty. After a victim is accepted, it stays low until `bus_wack` arrives for the issued write.
- R10: Reset empties all slots and the cast-out buffer: `slots_used` and `bus_inflight` are 0, `bus_req_valid` and `fill_valid` are low, and `cwb_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request present |
| req_is_inst | input | 1 | Request comes from the instruction cache |
| req_addr | input | 32 | Line address of the miss |
| req_ready | output | 1 | Request accepted this cycle |
| cwb_valid | input | 1 | Victim line offered |
| cwb_addr | input | 32 | Victim line address |
| cwb_data | input | 256 | Victim line data |
| cwb_ready | output | 1 | Cast-out buffer empty, victim taken |
| bus_req_valid | output | 1 | Transaction offered to the bus |
| bus_req_write | output | 1 | Offered transaction is the cast-out write |
| bus_req_addr | output | 32 | Line address of the offered transaction |
| bus_req_tag | output | 3 | Tag of the offered transaction |
| bus_req_data | output | 256 | Write data (zero for reads) |
| bus_req_ready | input | 1 | Bus takes the offered transaction |
| bus_wack | input | 1 | Cast-out write acknowledged |
| rsp_valid | input | 1 | Read data beat present |
| rsp_tag | input | 3 | Tag of the returning read |
| rsp_data | input | 256 | Full returning line |
| fill_valid | output | 1 | Line delivered to the caches |
| fill_inst | output | 1 | Delivered line is of instruction origin |
| fill_addr | output | 32 | Delivered line address |
| fill_data | output | 256 | Delivered line data |
| slots_used | output | 3 | Occupied miss slots |
| bus_inflight | output | 3 | Transactions outstanding on the bus |

## Verification
The assertions assume the bus acts on its own side. It returns data only for tags it was given, sends `bus_wack` only for a write it accepted, and at most one return per tag. A stray tag is the one exception, and the design must ignore it. The bench drives every request and victim at the falling edge and keeps it for exactly one cycle. Returns and acknowledgements are raised only after the matching issue has been observed. A merging request is never driven in the same cycle as the return for the slot it matches, so every retirement and every merge falls in a cycle of its own.

// File: rtl/fillq_pkg.sv
package fillq_pkg;

  // Origin of a miss slot
  typedef enum logic {
    SRC_DATA = 1'b0,
    SRC_INST = 1'b1
  } miss_src_e;

  // Bus transaction kind
  typedef enum logic {
    XFER_READ  = 1'b0,
    XFER_WRITE = 1'b1
  } xfer_kind_e;

endpackage

// File: rtl/fillq_slots.sv
module fillq_slots
  import fillq_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TAG_W   = 3,
  parameter int unsigned IDX_W   = $clog2(ENTRIES),
  parameter int unsigned CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic                             clk,
  input  logic                             rst_q,
  input  logic                             req_valid,
  input  miss_src_e                        req_src,
  input  logic [ADDR_W-1:0]                req_addr,
  output logic                             req_ready,
  output logic                             merge_hit,
  output logic                             alloc_fire,
  output logic [IDX_W-1:0]                 alloc_idx,
  input  logic                             iss_fire,
  input  logic [IDX_W-1:0]                 iss_idx,
  input  logic                             rsp_valid,
  input  logic [TAG_W-1:0]                 rsp_tag,
  output logic                             ret_fire,
  output logic [IDX_W-1:0]                 ret_idx,
  output logic [ENTRIES-1:0]               slot_valid,
  output logic [ENTRIES-1:0]               slot_inst,
  output logic [ENTRIES-1:0]               slot_issued,
  output logic [ENTRIES-1:0][ADDR_W-1:0]   slot_addr,
  output logic [CNT_W-1:0]                 used_cnt
);

  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic               full;
  logic               inst_present;
  logic [IDX_W-1:0]   free_idx;
  logic [ENTRIES-1:0] valid_d, inst_d, issued_d;

  // Address match against every held slot
  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      hit_vec[i] = slot_valid[i] && (slot_addr[i] == req_addr);
    end
  end

  assign any_hit      = |hit_vec;
  assign full         = &slot_valid;
  assign inst_present = |(slot_valid & slot_inst);

  // Lowest free slot index
  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!slot_valid[i]) free_idx = IDX_W'(i);
    end
  end

  // Acceptance depends on held state only
  assign req_ready  = any_hit || (!full && !((req_src == SRC_INST) && inst_present));
  assign merge_hit  = req_valid && any_hit;
  assign alloc_fire = req_valid && !any_hit && !full &&
                      !((req_src == SRC_INST) && inst_present);
  assign alloc_idx  = free_idx;

  // Return matching by tag
  assign ret_idx  = rsp_tag[IDX_W-1:0];
  assign ret_fire = rsp_valid && (rsp_tag < TAG_W'(ENTRIES)) &&
                    slot_valid[ret_idx] && slot_issued[ret_idx];

  // Occupancy count
  always_comb begin
    used_cnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      used_cnt = used_cnt + CNT_W'(slot_valid[i]);
    end
  end

  // Next state of slot control bits
  always_comb begin
    valid_d  = slot_valid;
    inst_d   = slot_inst;
    issued_d = slot_issued;
    if (ret_fire) begin
      valid_d[ret_idx]  = 1'b0;
      issued_d[ret_idx] = 1'b0;
    end
    if (iss_fire) begin
      issued_d[iss_idx] = 1'b1;
    end
    if (alloc_fire) begin
      valid_d[alloc_idx]  = 1'b1;
      inst_d[alloc_idx]   = (req_src == SRC_INST);
      issued_d[alloc_idx] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      slot_valid  <= '0;
      slot_inst   <= '0;
      slot_issued <= '0;
    end else begin
      slot_valid  <= valid_d;
      slot_inst   <= inst_d;
      slot_issued <= issued_d;
    end
  end

  // Address storage with per-slot write enable
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_addr
      logic addr_en;
      assign addr_en = alloc_fire && (alloc_idx == IDX_W'(g));
      always_ff @(posedge clk) begin
        if (addr_en) slot_addr[g] <= req_addr;
      end
    end
  endgenerate

endmodule

// File: rtl/fillq_order.sv
module fillq_order #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned IDX_W   = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_q,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic             not_empty,
  output logic [IDX_W-1:0] head_idx
);

  localparam int unsigned OCC_W = $clog2(ENTRIES + 1);

  logic [IDX_W-1:0] ring [ENTRIES];
  logic [IDX_W-1:0] rd_ptr, wr_ptr, rd_ptr_d, wr_ptr_d;
  logic [OCC_W-1:0] occ, occ_d;
  logic             do_pop;

  assign not_empty = (occ != '0);
  assign head_idx  = ring[rd_ptr];
  assign do_pop    = pop && not_empty;

  always_comb begin
    rd_ptr_d = rd_ptr;
    wr_ptr_d = wr_ptr;
    occ_d    = occ;
    if (push) begin
      wr_ptr_d = (wr_ptr == IDX_W'(ENTRIES - 1)) ? '0 : wr_ptr + 1'b1;
    end
    if (do_pop) begin
      rd_ptr_d = (rd_ptr == IDX_W'(ENTRIES - 1)) ? '0 : rd_ptr + 1'b1;
    end
    case ({push, do_pop})
      2'b10:   occ_d = occ + 1'b1;
      2'b01:   occ_d = occ - 1'b1;
      default: occ_d = occ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      rd_ptr <= rd_ptr_d;
      wr_ptr <= wr_ptr_d;
      occ    <= occ_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) ring[wr_ptr] <= push_idx;
  end

endmodule

// File: rtl/fillq_castout.sv
module fillq_castout #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              cwb_valid,
  input  logic [ADDR_W-1:0] cwb_addr,
  input  logic [LINE_W-1:0] cwb_data,
  output logic              cwb_ready,
  input  logic              co_iss_fire,
  input  logic              bus_wack,
  output logic              co_pend,
  output logic              co_busy,
  output logic [ADDR_W-1:0] co_addr,
  output logic [LINE_W-1:0] co_data
);

  logic held, sent, held_d, sent_d, load_en;

  assign cwb_ready = !held;
  assign load_en   = cwb_valid && !held;
  assign co_pend   = held && !sent;
  assign co_busy   = held && sent;

  always_comb begin
    held_d = held;
    sent_d = sent;
    if (load_en) begin
      held_d = 1'b1;
      sent_d = 1'b0;
    end else if (co_busy && bus_wack) begin
      held_d = 1'b0;
      sent_d = 1'b0;
    end else if (co_pend && co_iss_fire) begin
      sent_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      held <= 1'b0;
      sent <= 1'b0;
    end else begin
      held <= held_d;
      sent <= sent_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      co_addr <= cwb_addr;
      co_data <= cwb_data;
    end
  end

endmodule

// File: rtl/fillq_arb.sv
module fillq_arb #(
  parameter int unsigned SET_W = 6
) (
  input  logic             miss_avail,
  input  logic [SET_W-1:0] miss_set,
  input  logic             co_pend,
  input  logic [SET_W-1:0] co_set,
  output logic             any_req,
  output logic             pick_co
);

  logic set_clash;

  assign set_clash = (miss_set == co_set);
  assign any_req   = miss_avail || co_pend;
  assign pick_co   = co_pend && (!miss_avail || set_clash);

endmodule

// File: rtl/fillq_top.sv
module fillq_top
  import fillq_pkg::*;
#(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINE_W  = 256,
  parameter int unsigned TAG_W   = 3,
  parameter int unsigned SET_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_inst,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  input  logic              cwb_valid,
  input  logic [ADDR_W-1:0] cwb_addr,
  input  logic [LINE_W-1:0] cwb_data,
  output logic              cwb_ready,
  output logic              bus_req_valid,
  output logic              bus_req_write,
  output logic [ADDR_W-1:0] bus_req_addr,
  output logic [TAG_W-1:0]  bus_req_tag,
  output logic [LINE_W-1:0] bus_req_data,
  input  logic              bus_req_ready,
  input  logic              bus_wack,
  input  logic              rsp_valid,
  input  logic [TAG_W-1:0]  rsp_tag,
  input  logic [LINE_W-1:0] rsp_data,
  output logic              fill_valid,
  output logic              fill_inst,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [LINE_W-1:0] fill_data,
  output logic [$clog2(ENTRIES+1)-1:0] slots_used,
  output logic [$clog2(ENTRIES+2)-1:0] bus_inflight
);

  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned CNT_W  = $clog2(ENTRIES + 1);
  localparam int unsigned INF_W  = $clog2(ENTRIES + 2);
  localparam logic [TAG_W-1:0] CO_TAG = TAG_W'(ENTRIES);

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic                           merge_hit, alloc_fire, ret_fire;
  logic [IDX_W-1:0]               alloc_idx, ret_idx, head_idx;
  logic [ENTRIES-1:0]             slot_valid, slot_inst, slot_issued;
  logic [ENTRIES-1:0][ADDR_W-1:0] slot_addr;
  logic                           miss_avail, pick_co, any_req;
  logic                           miss_iss_fire, co_iss_fire;
  logic                           co_pend, co_busy;
  logic [ADDR_W-1:0]              co_addr;
  logic [LINE_W-1:0]              co_data;
  logic [ADDR_W-1:0]              head_addr;
  miss_src_e                      req_src;

  assign req_src = req_is_inst ? SRC_INST : SRC_DATA;

  fillq_slots #(
    .ENTRIES (ENTRIES),
    .ADDR_W  (ADDR_W),
    .TAG_W   (TAG_W)
  ) slots_i (
    .clk         (clk),
    .rst_q       (rst_q),
    .req_valid   (req_valid),
    .req_src     (req_src),
    .req_addr    (req_addr),
    .req_ready   (req_ready),
    .merge_hit   (merge_hit),
    .alloc_fire  (alloc_fire),
    .alloc_idx   (alloc_idx),
    .iss_fire    (miss_iss_fire),
    .iss_idx     (head_idx),
    .rsp_valid   (rsp_valid),
    .rsp_tag     (rsp_tag),
    .ret_fire    (ret_fire),
    .ret_idx     (ret_idx),
    .slot_valid  (slot_valid),
    .slot_inst   (slot_inst),
    .slot_issued (slot_issued),
    .slot_addr   (slot_addr),
    .used_cnt    (slots_used)
  );

  fillq_order #(
    .ENTRIES (ENTRIES)
  ) order_i (
    .clk       (clk),
    .rst_q     (rst_q),
    .push      (alloc_fire),
    .push_idx  (alloc_idx),
    .pop       (miss_iss_fire),
    .not_empty (miss_avail),
    .head_idx  (head_idx)
  );

  fillq_castout #(
    .ADDR_W (ADDR_W),
    .LINE_W (LINE_W)
  ) castout_i (
    .clk         (clk),
    .rst_q       (rst_q),
    .cwb_valid   (cwb_valid),
    .cwb_addr    (cwb_addr),
    .cwb_data    (cwb_data),
    .cwb_ready   (cwb_ready),
    .co_iss_fire (co_iss_fire),
    .bus_wack    (bus_wack),
    .co_pend     (co_pend),
    .co_busy     (co_busy),
    .co_addr     (co_addr),
    .co_data     (co_data)
  );

  assign head_addr = slot_addr[head_idx];

  fillq_arb #(
    .SET_W (SET_W)
  ) arb_i (
    .miss_avail (miss_avail),
    .miss_set   (head_addr[SET_W-1:0]),
    .co_pend    (co_pend),
    .co_set     (co_addr[SET_W-1:0]),
    .any_req    (any_req),
    .pick_co    (pick_co)
  );

  // Bus request mux
  assign bus_req_valid = any_req;
  assign bus_req_write = pick_co;
  assign bus_req_addr  = pick_co ? co_addr : head_addr;
  assign bus_req_tag   = pick_co ? CO_TAG : TAG_W'(head_idx);
  assign bus_req_data  = pick_co ? co_data : '0;
  assign miss_iss_fire = any_req && bus_req_ready && !pick_co;
  assign co_iss_fire   = any_req && bus_req_ready && pick_co;

  // Outstanding transaction count
  always_comb begin
    bus_inflight = INF_W'(co_busy);
    for (int i = 0; i < ENTRIES; i++) begin
      bus_inflight = bus_inflight + INF_W'(slot_valid[i] && slot_issued[i]);
    end
  end

  // Line delivery
  assign fill_valid = ret_fire;
  assign fill_inst  = slot_inst[ret_idx];
  assign fill_addr  = slot_addr[ret_idx];
  assign fill_data  = rsp_data;

endmodule

// File: rtl/fillq_chk.sv
module fillq_chk #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned CNT_W   = 3,
  parameter int unsigned INF_W   = 3
) (
  input logic               clk,
  input logic               rst_q,
  input logic               req_valid,
  input logic               req_is_inst,
  input logic               req_ready,
  input logic               merge_hit,
  input logic [ENTRIES-1:0] slot_valid,
  input logic [ENTRIES-1:0] slot_inst,
  input logic [CNT_W-1:0]   slots_used,
  input logic [INF_W-1:0]   bus_inflight,
  input logic               cwb_ready,
  input logic               bus_wack,
  input logic               fill_valid
);

  AST_ONE_INST_SLOT: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(slot_valid & slot_inst) <= 1); // R2

  AST_INST_REFUSED: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && req_is_inst && ((slot_valid & slot_inst) != '0) && !merge_hit)
      |-> !req_ready); // R2

  AST_FULL_REFUSED: assert property (@(posedge clk) disable iff (!rst_q)
    (req_valid && (&slot_valid) && !merge_hit) |-> !req_ready); // R1

  AST_USED_BOUND: assert property (@(posedge clk) disable iff (!rst_q)
    slots_used <= CNT_W'(ENTRIES)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_q)
    bus_inflight <= INF_W'(ENTRIES + 1)); // R3

  AST_MERGE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_q)
    merge_hit |=> slots_used <= $past(slots_used)); // R8

  AST_CASTOUT_HELD: assert property (@(posedge clk) disable iff (!rst_q)
    (!cwb_ready && !bus_wack) |=> !cwb_ready); // R9

  AST_FILL_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_q)
    fill_valid |-> bus_inflight != '0); // R5

endmodule

bind fillq_top fillq_chk #(
  .ENTRIES (ENTRIES),
  .CNT_W   (CNT_W),
  .INF_W   (INF_W)
) chk_i (
  .clk          (clk),
  .rst_q        (rst_q),
  .req_valid    (req_valid),
  .req_is_inst  (req_is_inst),
  .req_ready    (req_ready),
  .merge_hit    (merge_hit),
  .slot_valid   (slot_valid),
  .slot_inst    (slot_inst),
  .slots_used   (slots_used),
  .bus_inflight (bus_inflight),
  .cwb_ready    (cwb_ready),
  .bus_wack     (bus_wack),
  .fill_valid   (fill_valid)
);

// File: tb/fillq_tb_top.sv
module fillq_top_tb_top;

  logic         clk;
  logic         rst_n;
  logic         req_valid, req_is_inst, req_ready;
  logic [31:0]  req_addr;
  logic         cwb_valid, cwb_ready;
  logic [31:0]  cwb_addr;
  logic [255:0] cwb_data;
  logic         bus_req_valid, bus_req_write, bus_req_ready, bus_wack;
  logic [31:0]  bus_req_addr;
  logic [2:0]   bus_req_tag;
  logic [255:0] bus_req_data;
  logic         rsp_valid;
  logic [2:0]   rsp_tag;
  logic [255:0] rsp_data;
  logic         fill_valid, fill_inst;
  logic [31:0]  fill_addr;
  logic [255:0] fill_data;
  logic [2:0]   slots_used;
  logic [2:0]   bus_inflight;

  int n_run  = 0;
  int n_fail = 0;

  fillq_top dut_i (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_is_inst (req_is_inst), .req_addr (req_addr),
    .req_ready (req_ready),
    .cwb_valid (cwb_valid), .cwb_addr (cwb_addr), .cwb_data (cwb_data),
    .cwb_ready (cwb_ready),
    .bus_req_valid (bus_req_valid), .bus_req_write (bus_req_write),
    .bus_req_addr (bus_req_addr), .bus_req_tag (bus_req_tag),
    .bus_req_data (bus_req_data), .bus_req_ready (bus_req_ready),
    .bus_wack (bus_wack),
    .rsp_valid (rsp_valid), .rsp_tag (rsp_tag), .rsp_data (rsp_data),
    .fill_valid (fill_valid), .fill_inst (fill_inst), .fill_addr (fill_addr),
    .fill_data (fill_data),
    .slots_used (slots_used), .bus_inflight (bus_inflight)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  localparam logic [31:0] A0 = 32'h100, A1 = 32'h201, A2 = 32'h302,
                          A3 = 32'h403, A4 = 32'h504, A5 = 32'h605,
                          A6 = 32'h706, A7 = 32'h808;
  localparam logic [31:0] V1 = 32'h93F, V2 = 32'hA46, V3 = 32'hB3E;

  // Row: {is_inst, addr, expected ready, expected slots_used after}
  localparam int NVEC = 10;
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b0, A0, 1'b1, 3'd1},  // R1 first data miss
    {1'b1, A1, 1'b1, 3'd2},  // R2 first inst miss
    {1'b1, A2, 1'b0, 3'd2},  // R2 second inst refused
    {1'b0, A0, 1'b1, 3'd2},  // R8 merge
    {1'b0, A3, 1'b1, 3'd3},
    {1'b0, A4, 1'b1, 3'd4},
    {1'b0, A5, 1'b0, 3'd4},  // R1 full refuses data
    {1'b1, A1, 1'b1, 3'd4},  // R8 merge while full
    {1'b0, A3, 1'b1, 3'd4},  // R8 merge while full
    {1'b1, A6, 1'b0, 3'd4}   // R2 inst refused, full
  };

  function automatic logic [255:0] line(input logic [31:0] k);
    return {8{32'hC0DE0000 ^ k}};
  endfunction

  task automatic check(input string rq, input logic [255:0] act,
                       input logic [255:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_req(input logic inst, input logic [31:0] a,
                          input logic exp_rdy, input logic [2:0] exp_used,
                          input string rq);
    req_valid = 1'b1; req_is_inst = inst; req_addr = a;
    #1 check(rq, req_ready, exp_rdy);
    tick();
    req_valid = 1'b0;
    #1 check(rq, slots_used, exp_used);
  endtask

  task automatic put_victim(input logic [31:0] a);
    cwb_valid = 1'b1; cwb_addr = a; cwb_data = line(a);
    #1 check("R9 accept when empty", cwb_ready, 1'b1);
    tick();
    cwb_valid = 1'b0;
    #1 check("R9 busy after accept", cwb_ready, 1'b0);
  endtask

  task automatic expect_issue(input logic wr, input logic [31:0] a,
                              input logic [2:0] tg, input string rq);
    bus_req_ready = 1'b1;
    #1;
    check(rq, bus_req_valid, 1'b1);
    check(rq, bus_req_write, wr);
    check(rq, bus_req_addr, a);
    check(rq, bus_req_tag, tg);
    if (wr) check("R7 write data", bus_req_data, line(a));
    tick();
    bus_req_ready = 1'b0;
  endtask

  task automatic give_rsp(input logic [2:0] tg, input logic vfill,
                          input logic [31:0] a, input logic inst, input string rq);
    rsp_valid = 1'b1; rsp_tag = tg; rsp_data = line(a);
    #1;
    check(rq, fill_valid, vfill);
    if (vfill) begin
      check("R4 fill addr", fill_addr, a);
      check("R4 fill data", fill_data, line(a));
      check("R4 fill origin", fill_inst, inst);
    end
    tick();
    rsp_valid = 1'b0;
  endtask

  task automatic reset_and_check(input string rq);
    rst_n = 1'b0;
    repeat (2) tick();
    #1;
    check(rq, slots_used, 3'd0);
    check(rq, bus_inflight, 3'd0);
    check(rq, bus_req_valid, 1'b0);
    check(rq, fill_valid, 1'b0);
    check(rq, cwb_ready, 1'b1);
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    req_valid = 0; req_is_inst = 0; req_addr = '0;
    cwb_valid = 0; cwb_addr = '0; cwb_data = '0;
    bus_req_ready = 0; bus_wack = 0;
    rsp_valid = 0; rsp_tag = '0; rsp_data = '0;
    rst_n = 1'b0;
    @(negedge clk);
    reset_and_check("R10 initial reset");

    // Allocation, mix limit and merge table
    for (int i = 0; i < NVEC; i++) begin
      send_req(VEC[i][36], VEC[i][35:4], VEC[i][3], VEC[i][2:0], "R1/R2/R8 table");
    end

    // Arrival-order issue, tag = slot index (R6, R5)
    expect_issue(1'b0, A0, 3'd0, "R6 issue 1st");
    expect_issue(1'b0, A1, 3'd1, "R6 issue 2nd");
    expect_issue(1'b0, A3, 3'd2, "R6 issue 3rd");
    expect_issue(1'b0, A4, 3'd3, "R6 issue 4th");
    #1 check("R3 four reads out", bus_inflight, 3'd4);

    // Cast-out with no miss waiting (R7, R9), five in flight (R3)
    put_victim(V1);
    expect_issue(1'b1, V1, 3'd4, "R7 castout alone");
    #1 check("R3 five in flight", bus_inflight, 3'd5);
    check("R9 held until ack", cwb_ready, 1'b0);

    // Stray tag ignored, out-of-order returns (R5, R4)
    give_rsp(3'd7, 1'b0, A0, 1'b0, "R5 stray tag");
    #1 check("R5 stray tag no change", bus_inflight, 3'd5);
    give_rsp(3'd2, 1'b1, A3, 1'b0, "R5 out of order tag2");
    #1 check("R3 after return", bus_inflight, 3'd4);
    check("R4 slot freed", slots_used, 3'd3);
    give_rsp(3'd1, 1'b1, A1, 1'b1, "R5 tag1 inst");
    #1 check("R4 slot freed 2", slots_used, 3'd2);

    // Inst slot freed: new inst accepted into lowest free slot 1 (R2, R5)
    send_req(1'b1, A6, 1'b1, 3'd3, "R2 inst after retire");
    bus_wack = 1'b1; tick(); bus_wack = 1'b0;
    #1 check("R9 empty after ack", cwb_ready, 1'b1);
    check("R3 after ack", bus_inflight, 3'd2);

    // Victim in same set as waiting miss goes first (R7)
    put_victim(V2);
    expect_issue(1'b1, V2, 3'd4, "R7 set clash castout first");
    expect_issue(1'b0, A6, 3'd1, "R5 inst in slot1");
    bus_wack = 1'b1; tick(); bus_wack = 1'b0;

    // Different set: miss goes first (R7)
    send_req(1'b0, A7, 1'b1, 3'd4, "R1 refill slot2");
    put_victim(V3);
    expect_issue(1'b0, A7, 3'd2, "R7 miss before castout");
    expect_issue(1'b1, V3, 3'd4, "R7 castout after miss");
    #1 check("R3 full five", bus_inflight, 3'd5);

    reset_and_check("R10 reset clears");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule